// File: doc/BRIEF.md
# Comparator Event Timer with Periodic Reload

This block is a memory-mapped event timer. A 64-bit main counter advances by one on every clock while a global run bit is set, and a parameterised number of comparator channels watch it. When the counter equals a channel's comparator, that channel raises a level status bit. In one-shot mode the comparator is left alone, so the channel fires once and software re-arms it by writing a new comparator. In periodic mode the counter is never reset; the comparator itself advances by a stored period, so software sees the comparator step forward at every event.

Software reaches every register through a plain 32-bit write/read port with a combinational read path. The period of a channel has no address of its own: it is loaded by an arming sequence. Setting the arming bit in the channel configuration makes the next comparator-low write load the comparator, and the one after it load the period. Each channel's status, gated by its interrupt enable, is routed to one of several interrupt lines. A legacy routing mode instead sends channel 0 and channel 1 to two dedicated outputs.

Top module: `evtmr_top`

Register map (byte offsets): 0x000 capability, 0x004 tick period, 0x010 global control, 0x018 status, 0x020 counter low, 0x024 counter high. Channel c sits at 0x100 + 0x20*c: +0x0 configuration, +0x8 comparator low, +0xC comparator high.

## Requirements
- R1: After reset the counter, the global control, all channel registers and all status bits read 0, and every interrupt output is low. The capability word at 0x000 reads NCH-1 in bits [4:0] and 1 in bit 8 (legacy routing available). The word at 0x004 reads TICK_FS, the tick period in femtoseconds.
- R2: The counter increments by exactly one per clock while global control bit 0 (run) is 1, and holds its value while run is 0.
- R3: Writes to 0x020 replace counter bits [31:0] and writes to 0x024 replace bits [63:32], but only while run is 0. While run is 1 such writes are ignored.
- R4: In one-shot mode (channel config bit 1 = 0) a match sets the channel's status bit and leaves the comparator unchanged.
- R5: In periodic mode (config bit 1 = 1) the comparator advances by the stored period on each match, and the counter continues without a reset.
- R6: Writing a channel config with bit 2 = 1 arms the sequence, and bit 2 then reads 1. The next comparator-low write loads comparator [31:0]. The following one loads period [31:0], after which bit 2 reads 0. A comparator-high write loads period [63:32] when only the period write remains, and comparator [63:32] otherwise. Writing config bit 2 = 0 does not cancel the sequence.
- R7: With config bit 3 = 1 (32-bit mode), only counter bits [31:0] are compared. Writes to the comparator-high word are ignored, and a periodic advance wraps within bits [31:0] while bits [63:32] stay the same.
- R8: The status word at 0x018 holds bit c for channel c. Writing 1 to a bit clears it, writing 0 leaves it, and a match in the same cycle as the clear keeps the bit set.
- R9: A channel is active when its status bit and its config bit 0 (interrupt enable) are both 1. An active channel drives irq_line[route], where route is config bits [9:8]. Each line is the OR of the channels routed to it.
- R10: When global control bit 1 (legacy) is 1, channel 0 drives irq_legacy_tmr and channel 1 drives irq_legacy_rtc, and neither drives irq_line. Other channels still use their route, and both legacy outputs stay low while legacy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_line | output | NLINES | Routed interrupt lines |
| irq_legacy_tmr | output | 1 | Legacy timer line for channel 0 |
| irq_legacy_rtc | output | 1 | Legacy clock line for channel 1 |

## Verification
The bench goes after the arming sequence. A design that counted comparator-high writes, or cleared the arm after one write, would put the period into the comparator, and the periodic events would land at the wrong cycles. It writes the counter while it runs, and a design that accepted the write would jump the counter away from the model. It drives a 32-bit periodic channel across the 2^32 boundary of the counter, where a full 64-bit compare or an add that carried into the high word would miss every event. It also clears a status bit and writes zeros to it, and toggles legacy routing, where wrong precedence would leak channel 0 or 1 onto a routed line.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CAP    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TICK   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_GCTL   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h024;

  localparam logic [3:0] CH_PAGE   = 4'h1;
  localparam logic [4:0] CH_CFG    = 5'h00;
  localparam logic [4:0] CH_CMP_LO = 5'h08;
  localparam logic [4:0] CH_CMP_HI = 5'h0C;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_CMP  = 2'd1,
    ARM_PER  = 2'd2
  } arm_e;
endpackage

// File: rtl/evtmr_counter.sv
module evtmr_counter (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] cnt_o
);
  logic [63:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) begin
      cnt_d = cnt_q + 64'd1;
    end else if (wr_lo_i) begin
      cnt_d[31:0] = wdata_i;
    end else if (wr_hi_i) begin
      cnt_d[63:32] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    run_i |=> cnt_q == $past(cnt_q) + 64'd1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
  import evtmr_pkg::*;
#(
  parameter int RT_W = 2
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [63:0]     cnt_i,
  input  logic            run_i,
  input  logic            cfg_wr_i,
  input  logic            cmp_lo_wr_i,
  input  logic            cmp_hi_wr_i,
  input  logic            sts_clr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     cfg_o,
  output logic [63:0]     cmp_o,
  output logic            sts_o,
  output logic            act_o,
  output logic [RT_W-1:0] route_o
);
  logic            ie_q, ie_d, per_q, per_d, m32_q, m32_d, sts_q, sts_d;
  logic [RT_W-1:0] rt_q, rt_d;
  arm_e            arm_q, arm_d;
  logic [63:0]     cmp_q, cmp_d, prd_q, prd_d;
  logic            hit;

  assign hit = run_i && (m32_q ? (cnt_i[31:0] == cmp_q[31:0]) : (cnt_i == cmp_q));

  always_comb begin
    ie_d  = ie_q;
    per_d = per_q;
    m32_d = m32_q;
    rt_d  = rt_q;
    arm_d = arm_q;
    cmp_d = cmp_q;
    prd_d = prd_q;
    if (hit && per_q) begin
      if (m32_q) cmp_d[31:0] = cmp_q[31:0] + prd_q[31:0];
      else       cmp_d       = cmp_q + prd_q;
    end
    if (cfg_wr_i) begin
      ie_d  = wdata_i[0];
      per_d = wdata_i[1];
      m32_d = wdata_i[3];
      rt_d  = wdata_i[8 +: RT_W];
      if (wdata_i[2]) arm_d = ARM_CMP;
    end
    if (cmp_lo_wr_i) begin
      unique case (arm_q)
        ARM_PER: begin prd_d[31:0] = wdata_i; arm_d = ARM_IDLE; end
        ARM_CMP: begin cmp_d[31:0] = wdata_i; arm_d = ARM_PER;  end
        default: cmp_d[31:0] = wdata_i;
      endcase
    end
    if (cmp_hi_wr_i && !m32_q) begin
      if (arm_q == ARM_PER) prd_d[63:32] = wdata_i;
      else                  cmp_d[63:32] = wdata_i;
    end
    sts_d = hit | (sts_q & ~sts_clr_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      per_q <= 1'b0;
      m32_q <= 1'b0;
      rt_q  <= '0;
      arm_q <= ARM_IDLE;
      cmp_q <= '0;
      prd_q <= '0;
      sts_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      per_q <= per_d;
      m32_q <= m32_d;
      rt_q  <= rt_d;
      arm_q <= arm_d;
      cmp_q <= cmp_d;
      prd_q <= prd_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    cfg_o = '0;
    cfg_o[0] = ie_q;
    cfg_o[1] = per_q;
    cfg_o[2] = (arm_q != ARM_IDLE);
    cfg_o[3] = m32_q;
    cfg_o[8 +: RT_W] = rt_q;
  end

  assign cmp_o   = cmp_q;
  assign sts_o   = sts_q;
  assign act_o   = sts_q & ie_q;
  assign route_o = rt_q;

  AST_ONESHOT_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && !per_q && !cmp_lo_wr_i && !cmp_hi_wr_i) |=> $stable(cmp_q)); // R4
  AST_PERIOD_ADV: assert property (@(posedge clk) disable iff (!rst_ni)
    (hit && per_q && !m32_q && !cmp_lo_wr_i && !cmp_hi_wr_i)
      |=> cmp_q == $past(cmp_q) + $past(prd_q)); // R5
  AST_M32_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (m32_q && !cmp_lo_wr_i) |=> $stable(cmp_q[63:32])); // R7
  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |=> sts_q); // R8
  AST_ARM_ORDER: assert property (@(posedge clk) disable iff (!rst_ni)
    (arm_q == ARM_CMP && cmp_lo_wr_i && !cfg_wr_i) |=> $stable(prd_q)); // R6
endmodule

// File: rtl/evtmr_route.sv
module evtmr_route #(
  parameter int NCH    = 3,
  parameter int NLINES = 4,
  parameter int RT_W   = 2
) (
  input  logic [NCH-1:0]      act_i,
  input  logic [NCH*RT_W-1:0] route_i,
  input  logic                legacy_i,
  output logic [NLINES-1:0]   line_o,
  output logic                leg_tmr_o,
  output logic                leg_rtc_o
);
  always_comb begin
    line_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (!(legacy_i && c < 2)) begin
        line_o[route_i[c*RT_W +: RT_W]] = line_o[route_i[c*RT_W +: RT_W]] | act_i[c];
      end
    end
  end

  assign leg_tmr_o = legacy_i & act_i[0];
  assign leg_rtc_o = legacy_i & act_i[1];
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int          NCH     = 3,
  parameter int          NLINES  = 4,
  parameter logic [31:0] TICK_FS = 32'd8000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NLINES-1:0] irq_line,
  output logic              irq_legacy_tmr,
  output logic              irq_legacy_rtc
);
  localparam int RT_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic run_q, run_d, leg_q, leg_d;
  logic gctl_wr;

  assign gctl_wr = reg_wr && (reg_addr == OFS_GCTL);

  always_comb begin
    run_d = run_q;
    leg_d = leg_q;
    if (gctl_wr) begin
      run_d = reg_wdata[0];
      leg_d = reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else begin
      run_q <= run_d;
      leg_q <= leg_d;
    end
  end

  logic [63:0] cnt;

  evtmr_counter u_cnt (
    .clk     (clk),
    .rst_ni  (rst_i),
    .run_i   (run_q),
    .wr_lo_i (reg_wr && (reg_addr == OFS_CNT_LO)),
    .wr_hi_i (reg_wr && (reg_addr == OFS_CNT_HI)),
    .wdata_i (reg_wdata),
    .cnt_o   (cnt)
  );

  logic [31:0]      ch_cfg [NCH];
  logic [63:0]      ch_cmp [NCH];
  logic [NCH-1:0]   ch_sts, ch_act;
  logic [NCH*RT_W-1:0] ch_rt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = reg_wr && (reg_addr[11:8] == CH_PAGE) && (reg_addr[7:5] == 3'(c));

    evtmr_channel #(.RT_W(RT_W)) u_ch (
      .clk         (clk),
      .rst_ni      (rst_i),
      .cnt_i       (cnt),
      .run_i       (run_q),
      .cfg_wr_i    (sel && (reg_addr[4:0] == CH_CFG)),
      .cmp_lo_wr_i (sel && (reg_addr[4:0] == CH_CMP_LO)),
      .cmp_hi_wr_i (sel && (reg_addr[4:0] == CH_CMP_HI)),
      .sts_clr_i   (reg_wr && (reg_addr == OFS_STAT) && reg_wdata[c]),
      .wdata_i     (reg_wdata),
      .cfg_o       (ch_cfg[c]),
      .cmp_o       (ch_cmp[c]),
      .sts_o       (ch_sts[c]),
      .act_o       (ch_act[c]),
      .route_o     (ch_rt[c*RT_W +: RT_W])
    );
  end

  evtmr_route #(.NCH(NCH), .NLINES(NLINES), .RT_W(RT_W)) u_route (
    .act_i     (ch_act),
    .route_i   (ch_rt),
    .legacy_i  (leg_q),
    .line_o    (irq_line),
    .leg_tmr_o (irq_legacy_tmr),
    .leg_rtc_o (irq_legacy_rtc)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CAP:    begin reg_rdata[4:0] = 5'(NCH - 1); reg_rdata[8] = 1'b1; end
      OFS_TICK:   reg_rdata = TICK_FS;
      OFS_GCTL:   reg_rdata[1:0] = {leg_q, run_q};
      OFS_STAT:   reg_rdata[NCH-1:0] = ch_sts;
      OFS_CNT_LO: reg_rdata = cnt[31:0];
      OFS_CNT_HI: reg_rdata = cnt[63:32];
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (reg_addr[11:8] == CH_PAGE && reg_addr[7:5] == 3'(c)) begin
            if (reg_addr[4:0] == CH_CFG)    reg_rdata = ch_cfg[c];
            if (reg_addr[4:0] == CH_CMP_LO) reg_rdata = ch_cmp[c][31:0];
            if (reg_addr[4:0] == CH_CMP_HI) reg_rdata = ch_cmp[c][63:32];
          end
        end
      end
    endcase
  end

  AST_LEG_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    !leg_q |-> (!irq_legacy_tmr && !irq_legacy_rtc)); // R10
endmodule

// File: tb/evtmr_top_tb_top.sv
`timescale 1ns/1ps
module evtmr_top_tb_top;
  localparam int          NCH     = 3;
  localparam int          NLINES  = 4;
  localparam logic [31:0] TICK_FS = 32'd8000000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [11:0]       reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NLINES-1:0] irq_line;
  logic              irq_legacy_tmr, irq_legacy_rtc;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evtmr_top #(.NCH(NCH), .NLINES(NLINES), .TICK_FS(TICK_FS)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line),
    .irq_legacy_tmr(irq_legacy_tmr), .irq_legacy_rtc(irq_legacy_rtc)
  );

  // behavioural reference
  bit [63:0] m_cnt;
  bit        m_run, m_leg;
  bit [63:0] m_cmp [NCH];
  bit [63:0] m_prd [NCH];
  bit        m_ie [NCH], m_pm [NCH], m_w32 [NCH], m_sts [NCH];
  bit [1:0]  m_rt [NCH];
  int        m_arm [NCH];   // 0 idle, 1 next low write = comparator, 2 next = period

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_run = 0; m_leg = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cmp[c] = '0; m_prd[c] = '0; m_ie[c] = 0; m_pm[c] = 0;
        m_w32[c] = 0; m_sts[c] = 0; m_rt[c] = '0; m_arm[c] = 0;
      end
    end else begin
      bit hit [NCH];
      for (int c = 0; c < NCH; c++) begin
        if (m_w32[c]) hit[c] = m_run && (m_cnt[31:0] == m_cmp[c][31:0]);
        else          hit[c] = m_run && (m_cnt == m_cmp[c]);
        if (hit[c] && m_pm[c]) begin
          if (m_w32[c]) m_cmp[c][31:0] = m_cmp[c][31:0] + m_prd[c][31:0];
          else          m_cmp[c] = m_cmp[c] + m_prd[c];
        end
      end
      if (m_run) m_cnt = m_cnt + 1;
      else if (reg_wr && reg_addr == 12'h020) m_cnt[31:0] = reg_wdata;
      else if (reg_wr && reg_addr == 12'h024) m_cnt[63:32] = reg_wdata;
      if (reg_wr) begin
        int a;
        a = int'(reg_addr);
        if (a == 'h010) begin m_run = reg_wdata[0]; m_leg = reg_wdata[1]; end
        if (a == 'h018) for (int c = 0; c < NCH; c++) if (reg_wdata[c]) m_sts[c] = 0;
        if (a >= 'h100 && a < 'h100 + 32 * NCH) begin
          int c, o;
          c = (a - 'h100) / 32;
          o = a % 32;
          if (o == 0) begin
            m_ie[c] = reg_wdata[0]; m_pm[c] = reg_wdata[1];
            m_w32[c] = reg_wdata[3]; m_rt[c] = reg_wdata[9:8];
            if (reg_wdata[2]) m_arm[c] = 1;
          end else if (o == 8) begin
            if (m_arm[c] == 2)      begin m_prd[c][31:0] = reg_wdata; m_arm[c] = 0; end
            else if (m_arm[c] == 1) begin m_cmp[c][31:0] = reg_wdata; m_arm[c] = 2; end
            else                    m_cmp[c][31:0] = reg_wdata;
          end else if (o == 12 && !m_w32[c]) begin
            if (m_arm[c] == 2) m_prd[c][63:32] = reg_wdata;
            else               m_cmp[c][63:32] = reg_wdata;
          end
        end
      end
      for (int c = 0; c < NCH; c++) if (hit[c]) m_sts[c] = 1;
    end
  end

  function automatic bit [31:0] mread(input int a);
    bit [31:0] r;
    r = '0;
    if (a == 'h000) begin r[4:0] = 5'(NCH - 1); r[8] = 1; end
    else if (a == 'h004) r = TICK_FS;
    else if (a == 'h010) r[1:0] = {m_leg, m_run};
    else if (a == 'h018) begin for (int c = 0; c < NCH; c++) r[c] = m_sts[c]; end
    else if (a == 'h020) r = m_cnt[31:0];
    else if (a == 'h024) r = m_cnt[63:32];
    else if (a >= 'h100 && a < 'h100 + 32 * NCH) begin
      int c, o;
      c = (a - 'h100) / 32;
      o = a % 32;
      if (o == 0) begin
        r[0] = m_ie[c]; r[1] = m_pm[c]; r[2] = (m_arm[c] != 0);
        r[3] = m_w32[c]; r[9:8] = m_rt[c];
      end else if (o == 8)  r = m_cmp[c][31:0];
      else if (o == 12)     r = m_cmp[c][63:32];
    end
    return r;
  endfunction

  // per-cycle interrupt comparison (R9 routing, R10 legacy)
  always @(negedge clk) begin
    if (live && !done) begin
      bit [NLINES-1:0] el;
      bit et, er;
      el = '0; et = 0; er = 0;
      for (int c = 0; c < NCH; c++) begin
        bit act;
        act = m_sts[c] & m_ie[c];
        if (m_leg && c == 0) et = act;
        else if (m_leg && c == 1) er = act;
        else el[m_rt[c]] = el[m_rt[c]] | act;
      end
      n_chk++;
      if (irq_line !== el || irq_legacy_tmr !== et || irq_legacy_rtc !== er) begin
        n_fail++;
        $display("FAIL %s irq outputs: got line=%b tmr=%b rtc=%b expected line=%b tmr=%b rtc=%b",
                 m_leg ? "R10" : "R9", irq_line, irq_legacy_tmr, irq_legacy_rtc, el, et, er);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    bit [31:0] e;
    @(negedge clk);
    reg_addr = a;
    #1;
    e = mread(int'(a));
    n_chk++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read 0x%03h: got 0x%08h expected 0x%08h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    idle(3);
    rst_n = 1'b1;
    idle(5);
    live = 1'b1;
    // R1 reset values
    rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h010, "R1");
    rd(12'h020, "R1"); rd(12'h024, "R1"); rd(12'h018, "R1");
    rd(12'h100, "R1"); rd(12'h148, "R1");
    // R3 counter writes while stopped
    wr(12'h020, 32'd100); rd(12'h020, "R3");
    wr(12'h024, 32'd5);   rd(12'h024, "R3");
    wr(12'h024, 32'd0);   rd(12'h024, "R3");
    idle(3); rd(12'h020, "R2");          // R2 holds while stopped
    // R4 one-shot on channel 0, route 2
    wr(12'h100, 32'h201);
    wr(12'h108, 32'd120);
    wr(12'h010, 32'd1);
    rd(12'h020, "R2");
    idle(30);
    rd(12'h020, "R2");
    rd(12'h018, "R4"); rd(12'h108, "R4");
    // R3 write ignored while running
    wr(12'h020, 32'd0); rd(12'h020, "R3");
    // R8 writing zero leaves, writing one clears
    wr(12'h018, 32'd0); rd(12'h018, "R8");
    wr(12'h018, 32'd1); rd(12'h018, "R8");
    // R6 arming sequence on channel 1, periodic, route 1
    wr(12'h120, 32'h107); rd(12'h120, "R6");
    wr(12'h124, 32'h0);   // unmapped offset: not part of the sequence
    wr(12'h120, 32'h103); rd(12'h120, "R6");   // bit 2 = 0 does not cancel
    wr(12'h128, 32'(m_cnt[31:0] + 32'd20)); rd(12'h120, "R6");
    wr(12'h128, 32'd15); rd(12'h120, "R6"); rd(12'h128, "R6");
    idle(25); rd(12'h128, "R5");
    idle(20); rd(12'h128, "R5"); rd(12'h018, "R5");
    wr(12'h018, 32'd2); rd(12'h018, "R8");
    idle(40); rd(12'h128, "R5");
    // R10 legacy routing
    wr(12'h100, 32'h201);
    wr(12'h108, 32'(m_cnt[31:0] + 32'd10));
    wr(12'h010, 32'd3); rd(12'h010, "R10");
    idle(40); rd(12'h018, "R10");
    wr(12'h018, 32'd3);
    idle(20);
    wr(12'h010, 32'd1);
    idle(20);
    // R7 32-bit mode on channel 2, route 3, across the 2^32 boundary
    wr(12'h010, 32'd0);
    wr(12'h018, 32'd7);
    wr(12'h120, 32'h000);
    wr(12'h024, 32'd1); wr(12'h020, 32'hFFFF_FFE0);
    wr(12'h140, 32'h30F);
    wr(12'h148, 32'hFFFF_FFF0);
    wr(12'h14C, 32'd7); rd(12'h14C, "R7");
    wr(12'h148, 32'h20);
    rd(12'h140, "R6");
    wr(12'h010, 32'd1);
    idle(20); rd(12'h018, "R7"); rd(12'h148, "R7"); rd(12'h14C, "R7");
    wr(12'h018, 32'd4);
    idle(30); rd(12'h024, "R7"); rd(12'h018, "R7"); rd(12'h148, "R7");
    idle(10);
    rd(12'h020, "R2");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule